// File: doc/BRIEF.md
# ADC Front-End Control and Status Registers

This block is the host-facing register file of an analog-to-digital front end that has three conversion engines: an auxiliary-input engine, a battery-voltage engine and a touch-panel engine. A host reaches it over a simple read/write register bus with byte offsets. Each engine connects through a start/done handshake. While its enable bit is set, the matching `eng_start` line is high. The engine answers with a one-cycle `eng_done` pulse and its result on `eng_result`.

The auxiliary and battery enable bits are single-shot. Each one drops by itself when its conversion completes, so software starts a conversion by setting the bit and detects the end by polling until it reads back zero. Clearing the bit early aborts the conversion. The touch enable bit stays set and keeps streaming results.

Every completion, and each pen or sleep event from the touch side, raises a sticky status bit. Software clears a status bit by writing one to it. A mask register gates the status bits onto a single interrupt line. At reset every source is masked.

Top module: `adcif_top`

## Requirements
- R1: After reset the enable register reads 0, the mask register reads 0xFF, the status register reads 0, all three data registers read 0, and `irq`, `pwr_down` and `eng_start` are 0.
- R2: Registers and their offsets:
  - 0x04: configuration, 32 bits, also driven on `cfg_word`.
  - 0x10: same-sample count, low 16 bits.
  - 0x14: wait count, low 16 bits.
  - 0x24: command, 32 bits.
  - 0x28: clock divider, 32 bits.
  Each of these reads back the value written to it. Any offset outside the map reads 0. A read returns its data on `bus_rdata` in the cycle after `bus_rd`.
- R3: In the enable register at 0x00, bit 0 starts the auxiliary engine, bit 1 the battery engine and bit 2 the touch engine. Each `eng_start[k]` follows enable bit k. Bit 7 drives `pwr_down`. The auxiliary and battery bits return to 0 on their own when a done pulse arrives while they are set.
- R4: A completion is a done pulse while the enable bit is set. It latches the engine result (12 bits, zero-extended) into the engine's data register: auxiliary at 0x20, battery at 0x1C, touch at 0x18. It also sets the engine's status bit (auxiliary bit 0, battery bit 1, touch bit 2) at the same clock edge at which a single-shot enable bit clears.
- R5: The touch enable bit stays set after each completion. Every later completion updates the touch data register and sets status bit 2 again.
- R6: Writing 0 to an engine bit aborts that engine. A done pulse that arrives while the bit is 0 changes neither the data register nor the status register.
- R7: `pen_evt` bits 0, 1, 2 and 3 (pen down, pen up, pen down while asleep, sleep) set status bits 3, 4, 5 and 7 respectively. Status bit 6 always reads 0.
- R8: The status register at 0x0C is write-one-to-clear. A written 1 clears its bit and a written 0 leaves its bit unchanged. If an event sets a bit in the same cycle that a write clears it, the bit ends up set.
- R9: The mask register at 0x08 holds one mask bit per status bit, where 1 means masked. `irq` is high exactly when some status bit is set while its mask bit is 0. It reflects the register contents from the clock edge that updates them.
- R10: When an enable write and a completion of the same engine fall in one cycle, the completion still latches data and sets status, and the written value decides the new enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd`, otherwise 0 |
| eng_start | output | 3 | Run request per engine (aux, battery, touch) |
| eng_done | input | 3 | One-cycle completion pulse per engine |
| eng_result | input | 3*RES_W | Packed engine results, engine k in slice k |
| pen_evt | input | 4 | Pen down, pen up, pen down asleep, sleep event pulses |
| pwr_down | output | 1 | Power-down control from enable bit 7 |
| cfg_word | output | 32 | Contents of the configuration register |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: 12-bit results and 16-bit count registers. With these values the zero-extension of results into their 16-bit read fields and the truncation of wide writes to the count registers both become observable. The run covers several pairings of a completion with a host write in the same cycle: an enable rewrite, a status clear racing an event, and a done pulse after an abort. A behavioural model that tracks every register is compared with all outputs on every cycle.

// File: rtl/adcif_pkg.sv
package adcif_pkg;
  localparam int WORD_W     = 32;
  localparam int REG_ADDR_W = 6;
  localparam int NUM_ENG    = 3;
  localparam int SRC_W      = 8;
  localparam int EVT_W      = 4;

  localparam int ENG_AUX   = 0;
  localparam int ENG_BATT  = 1;
  localparam int ENG_TOUCH = 2;
  localparam int PD_BIT    = 7;

  // Status bit 6 has no source.
  localparam logic [SRC_W-1:0] STAT_IMPL = 8'hBF;

  typedef enum logic [REG_ADDR_W-1:0] {
    OFS_ENABLE = 6'h00,
    OFS_CONFIG = 6'h04,
    OFS_MASK   = 6'h08,
    OFS_STATUS = 6'h0C,
    OFS_SAME   = 6'h10,
    OFS_WAIT   = 6'h14,
    OFS_TOUCH  = 6'h18,
    OFS_BATT   = 6'h1C,
    OFS_AUX    = 6'h20,
    OFS_CMD    = 6'h24,
    OFS_CLKDIV = 6'h28
  } reg_ofs_e;
endpackage

// File: rtl/adcif_eng_slot.sv
module adcif_eng_slot #(
  parameter int RES_W    = 12,
  parameter bit ONE_SHOT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_we,
  input  logic             en_wbit,
  input  logic             done,
  input  logic [RES_W-1:0] result,
  output logic             en_q,
  output logic [RES_W-1:0] data_q,
  output logic             cmpl
);
  // A done pulse only counts while the engine is running.
  assign cmpl = done & en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      data_q <= '0;
    end else begin
      if (cmpl) data_q <= result;
      if (en_we)                 en_q <= en_wbit;
      else if (cmpl && ONE_SHOT) en_q <= 1'b0;
    end
  end
endmodule

// File: rtl/adcif_irq_ctrl.sv
module adcif_irq_ctrl
  import adcif_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_W-1:0] set_vec,
  input  logic             mask_we,
  input  logic             stat_we,
  input  logic [SRC_W-1:0] wdata,
  output logic [SRC_W-1:0] mask_q,
  output logic [SRC_W-1:0] stat_q,
  output logic             irq
);
  logic [SRC_W-1:0] clr_vec, stat_d, mask_d;

  always_comb begin
    clr_vec = stat_we ? wdata : '0;
    // Set beats clear so that no event is lost.
    stat_d  = ((stat_q & ~clr_vec) | set_vec) & STAT_IMPL;
    mask_d  = mask_we ? wdata : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      mask_q <= '1;
      irq    <= 1'b0;
    end else begin
      stat_q <= stat_d;
      mask_q <= mask_d;
      irq    <= |(stat_d & ~mask_d);
    end
  end
endmodule

// File: rtl/adcif_top.sv
module adcif_top
  import adcif_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int CNT_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [REG_ADDR_W-1:0]    bus_addr,
  input  logic [WORD_W-1:0]        bus_wdata,
  output logic [WORD_W-1:0]        bus_rdata,
  output logic [NUM_ENG-1:0]       eng_start,
  input  logic [NUM_ENG-1:0]       eng_done,
  input  logic [NUM_ENG*RES_W-1:0] eng_result,
  input  logic [EVT_W-1:0]         pen_evt,
  output logic                     pwr_down,
  output logic [WORD_W-1:0]        cfg_word,
  output logic                     irq
);
  logic             en_wr, mask_wr, stat_wr;
  logic [NUM_ENG-1:0] eng_en, eng_cmpl;
  logic [RES_W-1:0] eng_data [NUM_ENG];
  logic             pd_q;
  logic [WORD_W-1:0] cfg_q, cmd_q, div_q, rd_val, rdata_q;
  logic [CNT_W-1:0] same_q, wait_q;
  logic [SRC_W-1:0] set_vec, mask_q, stat_q;

  assign en_wr   = bus_wr && (bus_addr == OFS_ENABLE);
  assign mask_wr = bus_wr && (bus_addr == OFS_MASK);
  assign stat_wr = bus_wr && (bus_addr == OFS_STATUS);

  for (genvar g = 0; g < NUM_ENG; g++) begin : g_eng
    adcif_eng_slot #(
      .RES_W   (RES_W),
      .ONE_SHOT(g != ENG_TOUCH)
    ) u_slot (
      .clk    (clk),
      .rst    (rst),
      .en_we  (en_wr),
      .en_wbit(bus_wdata[g]),
      .done   (eng_done[g]),
      .result (eng_result[g*RES_W +: RES_W]),
      .en_q   (eng_en[g]),
      .data_q (eng_data[g]),
      .cmpl   (eng_cmpl[g])
    );
  end

  assign set_vec = {pen_evt[3], 1'b0, pen_evt[2], pen_evt[1], pen_evt[0], eng_cmpl};

  adcif_irq_ctrl u_irq (
    .clk    (clk),
    .rst    (rst),
    .set_vec(set_vec),
    .mask_we(mask_wr),
    .stat_we(stat_wr),
    .wdata  (bus_wdata[SRC_W-1:0]),
    .mask_q (mask_q),
    .stat_q (stat_q),
    .irq    (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pd_q   <= 1'b0;
      cfg_q  <= '0;
      cmd_q  <= '0;
      div_q  <= '0;
      same_q <= '0;
      wait_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        OFS_ENABLE: pd_q   <= bus_wdata[PD_BIT];
        OFS_CONFIG: cfg_q  <= bus_wdata;
        OFS_SAME:   same_q <= bus_wdata[CNT_W-1:0];
        OFS_WAIT:   wait_q <= bus_wdata[CNT_W-1:0];
        OFS_CMD:    cmd_q  <= bus_wdata;
        OFS_CLKDIV: div_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_ENABLE: rd_val = WORD_W'({pd_q, 4'b0000, eng_en});
      OFS_CONFIG: rd_val = cfg_q;
      OFS_MASK:   rd_val = WORD_W'(mask_q);
      OFS_STATUS: rd_val = WORD_W'(stat_q);
      OFS_SAME:   rd_val = WORD_W'(same_q);
      OFS_WAIT:   rd_val = WORD_W'(wait_q);
      OFS_TOUCH:  rd_val = WORD_W'(eng_data[ENG_TOUCH]);
      OFS_BATT:   rd_val = WORD_W'(eng_data[ENG_BATT]);
      OFS_AUX:    rd_val = WORD_W'(eng_data[ENG_AUX]);
      OFS_CMD:    rd_val = cmd_q;
      OFS_CLKDIV: rd_val = div_q;
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_val;
    else             rdata_q <= '0;
  end

  assign bus_rdata = rdata_q;
  assign eng_start = eng_en;
  assign pwr_down  = pd_q;
  assign cfg_word  = cfg_q;
endmodule

// File: rtl/adcif_chk.sv
module adcif_chk
  import adcif_pkg::*;
#(
  parameter int RES_W = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               en_wr,
  input logic [NUM_ENG-1:0] eng_en,
  input logic [NUM_ENG-1:0] eng_done,
  input logic [SRC_W-1:0]   stat_q,
  input logic [SRC_W-1:0]   mask_q,
  input logic               irq,
  input logic [RES_W-1:0]   bat_data
);
  AST_AUX_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    eng_en[0] && eng_done[0] && !en_wr |=> !eng_en[0]); // R3
  AST_BAT_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    eng_en[1] && eng_done[1] && !en_wr |=> !eng_en[1]); // R3
  AST_AUX_DONE_STATUS: assert property (@(posedge clk) disable iff (rst)
    eng_en[0] && eng_done[0] |=> stat_q[0]); // R4
  AST_TOUCH_STAYS_ON: assert property (@(posedge clk) disable iff (rst)
    eng_en[2] && eng_done[2] && !en_wr |=> eng_en[2] && stat_q[2]); // R5
  AST_IDLE_DONE_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    !eng_en[1] && eng_done[1] |=> $stable(bat_data)); // R6
  AST_BIT6_ZERO: assert property (@(posedge clk) disable iff (rst)
    !stat_q[6]); // R7
  AST_IRQ_MATCHES_MASK: assert property (@(posedge clk) disable iff (rst)
    irq == |(stat_q & ~mask_q)); // R9
endmodule

bind adcif_top adcif_chk #(.RES_W(RES_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .en_wr   (en_wr),
  .eng_en  (eng_en),
  .eng_done(eng_done),
  .stat_q  (stat_q),
  .mask_q  (mask_q),
  .irq     (irq),
  .bat_data(eng_data[ENG_BATT])
);

// File: tb/sim_adcif_top.sv
`timescale 1ns/1ps
module sim_adcif_top;
  localparam int RES_W = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tb_wr = 1'b0, tb_rd = 1'b0;
  logic [5:0]  tb_addr = '0;
  logic [31:0] tb_wdata = '0;
  logic [2:0]  tb_done = '0;
  logic [11:0] tb_res = '0;
  logic [3:0]  tb_evt = '0;
  logic [31:0] rdata, cfg_word;
  logic [2:0]  eng_start;
  logic        pwr_down, irq;

  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  adcif_top u0 (
    .clk(clk), .rst(rst), .bus_wr(tb_wr), .bus_rd(tb_rd), .bus_addr(tb_addr),
    .bus_wdata(tb_wdata), .bus_rdata(rdata), .eng_start(eng_start),
    .eng_done(tb_done), .eng_result({tb_res, tb_res, tb_res}), .pen_evt(tb_evt),
    .pwr_down(pwr_down), .cfg_word(cfg_word), .irq(irq)
  );

  // Behavioural reference model
  logic [2:0]  m_en;
  logic        m_pd, m_irq;
  logic [11:0] m_data [3];
  logic [7:0]  m_stat, m_mask;
  logic [31:0] m_cfg, m_cmd, m_div, m_rdata;
  logic [15:0] m_same, m_wait;

  function automatic logic [31:0] mread(input logic [5:0] a);
    case (a)
      6'h00: return {24'd0, m_pd, 4'd0, m_en};
      6'h04: return m_cfg;
      6'h08: return {24'd0, m_mask};
      6'h0C: return {24'd0, m_stat};
      6'h10: return {16'd0, m_same};
      6'h14: return {16'd0, m_wait};
      6'h18: return {20'd0, m_data[2]};
      6'h1C: return {20'd0, m_data[1]};
      6'h20: return {20'd0, m_data[0]};
      6'h24: return m_cmd;
      6'h28: return m_div;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_pd = 0; m_stat = 0; m_mask = 8'hFF; m_cfg = 0; m_cmd = 0;
      m_div = 0; m_same = 0; m_wait = 0; m_rdata = 0; m_irq = 0;
      for (int k = 0; k < 3; k++) m_data[k] = 0;
    end else begin
      logic [2:0] fin;
      logic [7:0] clr, setv;
      m_rdata = tb_rd ? mread(tb_addr) : 32'd0;
      fin = tb_done & m_en;
      for (int k = 0; k < 3; k++) if (fin[k]) m_data[k] = tb_res;
      if (tb_wr && tb_addr == 6'h00) begin
        m_en = tb_wdata[2:0];
        m_pd = tb_wdata[7];
      end else begin
        m_en[0] = m_en[0] & ~fin[0];
        m_en[1] = m_en[1] & ~fin[1];
      end
      clr  = (tb_wr && tb_addr == 6'h0C) ? tb_wdata[7:0] : 8'h00;
      setv = {tb_evt[3], 1'b0, tb_evt[2:0], fin};
      m_stat = (m_stat & ~clr) | setv;
      if (tb_wr && tb_addr == 6'h08) m_mask = tb_wdata[7:0];
      if (tb_wr && tb_addr == 6'h04) m_cfg = tb_wdata;
      if (tb_wr && tb_addr == 6'h10) m_same = tb_wdata[15:0];
      if (tb_wr && tb_addr == 6'h14) m_wait = tb_wdata[15:0];
      if (tb_wr && tb_addr == 6'h24) m_cmd = tb_wdata;
      if (tb_wr && tb_addr == 6'h28) m_div = tb_wdata;
      m_irq = |(m_stat & ~m_mask);
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R2 rdata", rdata, m_rdata);
      chk("R3 eng_start", {29'd0, eng_start}, {29'd0, m_en});
      chk("R3 pwr_down", {31'd0, pwr_down}, {31'd0, m_pd});
      chk("R9 irq", {31'd0, irq}, {31'd0, m_irq});
      chk("R2 cfg_word", cfg_word, m_cfg);
    end
  end

  task automatic cyc(input logic w, input logic r, input logic [5:0] a, input logic [31:0] d,
                     input logic [2:0] dn, input logic [11:0] res, input logic [3:0] ev);
    @(posedge clk); #2;
    tb_wr = w; tb_rd = r; tb_addr = a; tb_wdata = d; tb_done = dn; tb_res = res; tb_evt = ev;
    @(posedge clk); #2;
    tb_wr = 0; tb_rd = 0; tb_done = 0; tb_evt = 0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    cyc(1, 0, a, d, 3'b000, 12'h0, 4'h0);
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string req);
    cyc(0, 1, a, 32'd0, 3'b000, 12'h0, 4'h0);
    #5 chk(req, rdata, exp);
  endtask

  task automatic done(input int k, input logic [11:0] res);
    cyc(0, 0, 6'h00, 32'd0, 3'(1 << k), res, 4'h0);
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 0;
    // R1 reset state
    rd_chk(6'h00, 32'h0, "R1 enable");
    rd_chk(6'h08, 32'hFF, "R1 mask");
    rd_chk(6'h0C, 32'h0, "R1 status");
    rd_chk(6'h18, 32'h0, "R1 touch data");
    rd_chk(6'h1C, 32'h0, "R1 batt data");
    rd_chk(6'h20, 32'h0, "R1 aux data");
    chk("R1 irq", {31'd0, irq}, 32'd0);
    // R2 storage registers
    wr(6'h04, 32'hDEADBEEF); rd_chk(6'h04, 32'hDEADBEEF, "R2 config");
    chk("R2 cfg_word", cfg_word, 32'hDEADBEEF);
    wr(6'h10, 32'h00012345); rd_chk(6'h10, 32'h00002345, "R2 same count");
    wr(6'h14, 32'hFFFF0050); rd_chk(6'h14, 32'h00000050, "R2 wait count");
    wr(6'h24, 32'h0000A5A5); rd_chk(6'h24, 32'h0000A5A5, "R2 command");
    wr(6'h28, 32'h00030201); rd_chk(6'h28, 32'h00030201, "R2 clkdiv");
    rd_chk(6'h2C, 32'h0, "R2 unmapped");
    rd_chk(6'h3C, 32'h0, "R2 unmapped high");
    // R3 / R4 auxiliary single shot
    wr(6'h00, 32'h01);
    chk("R3 start aux", {29'd0, eng_start}, 32'd1);
    done(0, 12'hABC);
    rd_chk(6'h00, 32'h0, "R3 aux bit self clear");
    rd_chk(6'h20, 32'h0ABC, "R4 aux data");
    rd_chk(6'h0C, 32'h01, "R4 aux status");
    chk("R9 masked irq", {31'd0, irq}, 32'd0);
    // R9 mask, R8 W1C
    wr(6'h08, 32'hFE);
    chk("R9 irq unmasked", {31'd0, irq}, 32'd1);
    wr(6'h0C, 32'h00);
    rd_chk(6'h0C, 32'h01, "R8 zero write keeps");
    wr(6'h0C, 32'h01);
    rd_chk(6'h0C, 32'h00, "R8 one clears");
    chk("R9 irq after clear", {31'd0, irq}, 32'd0);
    // R4 battery
    wr(6'h00, 32'h02);
    done(1, 12'h123);
    rd_chk(6'h1C, 32'h0123, "R4 batt data");
    rd_chk(6'h0C, 32'h02, "R4 batt status");
    rd_chk(6'h00, 32'h0, "R3 batt bit self clear");
    wr(6'h0C, 32'h02);
    // R6 abort
    wr(6'h00, 32'h01);
    wr(6'h00, 32'h00);
    done(0, 12'h555);
    rd_chk(6'h20, 32'h0ABC, "R6 aux data kept");
    rd_chk(6'h0C, 32'h00, "R6 no status");
    // R5 touch continuous
    wr(6'h00, 32'h04);
    done(2, 12'h321);
    done(2, 12'h777);
    rd_chk(6'h00, 32'h04, "R5 touch bit held");
    rd_chk(6'h18, 32'h0777, "R5 touch data");
    rd_chk(6'h0C, 32'h04, "R5 touch status");
    wr(6'h00, 32'h00);
    // R7 pen events
    cyc(0, 0, 6'h00, 32'd0, 3'b000, 12'h0, 4'hF);
    rd_chk(6'h0C, 32'hBC, "R7 event bits");
    wr(6'h08, 32'h7F);
    chk("R9 irq sleep", {31'd0, irq}, 32'd1);
    wr(6'h0C, 32'hFF);
    rd_chk(6'h0C, 32'h00, "R8 clear all");
    // R8 set beats clear
    cyc(1, 0, 6'h0C, 32'h08, 3'b000, 12'h0, 4'h1);
    rd_chk(6'h0C, 32'h08, "R8 set wins");
    wr(6'h0C, 32'h08);
    // R10 write and completion together
    wr(6'h00, 32'h01);
    cyc(1, 0, 6'h00, 32'h03, 3'b001, 12'h999, 4'h0);
    rd_chk(6'h20, 32'h0999, "R10 data latched");
    rd_chk(6'h0C, 32'h01, "R10 status set");
    rd_chk(6'h00, 32'h03, "R10 written enable");
    done(1, 12'h456);
    rd_chk(6'h00, 32'h01, "R10 batt then clears");
    rd_chk(6'h1C, 32'h0456, "R4 batt data second");
    // R3 power-down
    wr(6'h00, 32'h80);
    chk("R3 pwr_down", {31'd0, pwr_down}, 32'd1);
    rd_chk(6'h00, 32'h80, "R3 enable pd bit");
    repeat (3) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule